// File: doc/BRIEF.md
# Row Scan Transfer Sequencer

This block refreshes a 1/16-scan dot-matrix panel without processor help. Once started, it loads each of sixteen row groups in turn. For every group it reads a programmed number of 16-bit words from a synchronous source memory. It writes each word onto a parallel panel bus, where the panel's first-level column latches capture it. After the last word of a group it pulses the panel's second-level latch strobe. It then moves the row select to the group that was just loaded, so that group is displayed while the next one is being loaded.

Software supplies a source base address, a destination base address and a word count per row, then pulses start. Source words are consumed one after another through the whole frame. The destination window restarts at its base for every row, because every row group occupies the same panel address range. After sixteen groups the sequencer pulses frame-done, drops busy and returns to idle with its row index wrapped to zero.

Top module: `rsq_top`

## Requirements
- R1: After reset, busy_o, frame_done_o, bus_cs_o, bus_we_o, row_latch_o and mem_rd_en_o are 0, and row_sel_o is 0.
- R2: A start_i pulse seen while idle captures src_base_i, dst_base_i and word_cnt_i. busy_o is 1 from the next cycle until the cycle after frame_done_o.
- R3: Row r (0 to 15) with count N reads source addresses src_base + r*N + i for i = 0 to N-1, in that order. mem_rd_data_i is valid in the cycle after mem_rd_en_o. The word read is written to the bus unchanged.
- R4: Word i of every row is written to bus address dst_base + 2*i, so the destination restarts at dst_base for each row.
- R5: Each write takes three bus cycles. First, address and data are presented with bus_cs_o and bus_we_o both 0. Next, bus_cs_o is 1 and bus_we_o is 0. Last, both are 1. Address and data do not change while bus_cs_o is 1.
- R6: After the last write of a row, row_latch_o is 1 for exactly one cycle, with bus_cs_o at 0.
- R7: row_sel_o does not change in the cycle row_latch_o is 1. In the following cycle it equals the index of the row just latched.
- R8: A frame is 16 row groups. frame_done_o is a one-cycle pulse after the 16th strobe, and the next frame starts again at row 0. With count N, frame_done_o occurs 16*(5N+2) cycles after the start edge.
- R9: A start_i pulse while busy_o is 1 has no effect on addresses, data, row order or frame timing.
- R10: A word count of 0 produces no bus write or memory read. Each row goes straight to its strobe, so a frame takes 32 cycles.
- R11: Word counts up to 4096 per row are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a frame (honoured only while idle) |
| src_base_i | input | 24 | Source memory word address of the first word |
| dst_base_i | input | 24 | Panel bus byte address of the first latch |
| word_cnt_i | input | 13 | Words per row group, 0 to 4096 |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | One-cycle pulse at the end of a frame |
| mem_rd_en_o | output | 1 | Source memory read enable |
| mem_addr_o | output | 24 | Source memory word address |
| mem_rd_data_i | input | 16 | Read data, valid the cycle after the read enable |
| bus_addr_o | output | 24 | Panel bus address |
| bus_data_o | output | 16 | Panel bus write data |
| bus_cs_o | output | 1 | Panel chip select, active high |
| bus_we_o | output | 1 | Panel write strobe, active high |
| row_latch_o | output | 1 | Second-level latch strobe |
| row_sel_o | output | 4 | Row group being displayed |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- the write strobe only rises inside an asserted chip select;
- address and data hold still while the chip select is high;
- the latch strobe never overlaps the chip select;
- the row select holds during the strobe and then takes the latched index;
- frame-done is a single pulse that ends busy.

The directed scenarios have to show the rest:
- the address arithmetic across rows, which includes the source words running on and the destination restarting;
- the exact frame length for several counts, including zero;
- the wrap back to row 0 on a second frame;
- that a start pulse during a frame changes nothing.

// File: rtl/rsq_pkg.sv
// Shared types for the row scan transfer sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rsq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_READ,   // memory read issued
        ST_WAIT,   // read data arriving, captured into bus registers
        ST_SETUP,  // address/data on bus, no strobes
        ST_SEL,    // chip select asserted
        ST_WRITE,  // chip select plus write strobe
        ST_LATCH,  // second-level latch strobe
        ST_NEXT    // advance row or finish frame
    } rsq_state_e;
endpackage

// File: rtl/rsq_ptrs.sv
// Address and data path: source read pointer, destination pointer,
// word index within the current row and the bus output registers.
// Assumes: read data is valid in the cycle after the read is issued
// (it is captured on cap_i), and word counts never exceed MAX_WORDS.
module rsq_ptrs #(
    parameter int AW        = 24,
    parameter int DW        = 16,
    parameter int MAX_WORDS = 4096,
    localparam int CW       = $clog2(MAX_WORDS + 1),
    localparam int STEP     = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [AW-1:0] src_base_i,
    input  logic [AW-1:0] dst_base_i,
    input  logic [CW-1:0] word_cnt_i,
    input  logic          cap_i,
    input  logic          word_adv_i,
    input  logic          row_adv_i,
    input  logic [DW-1:0] mem_rd_data_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_data_o,
    output logic          cnt_zero_o,
    output logic          last_word_o
);
    logic [AW-1:0] src_ptr, dst_ptr, dst_base_q;
    logic [CW-1:0] cnt_q, widx;

    // Source pointer: loads at start, steps one word per captured read.
    always_ff @(posedge clk) begin
        if (!rst_n)      src_ptr <= '0;
        else if (ld_i)   src_ptr <= src_base_i;
        else if (cap_i)  src_ptr <= src_ptr + AW'(1);
    end

    // Destination pointer and its base: one bus word per write, restarts per row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_ptr    <= '0;
            dst_base_q <= '0;
        end else if (ld_i) begin
            dst_ptr    <= dst_base_i;
            dst_base_q <= dst_base_i;
        end else if (row_adv_i) begin
            dst_ptr    <= dst_base_q;
        end else if (word_adv_i) begin
            dst_ptr    <= dst_ptr + AW'(STEP);
        end
    end

    // Word count and word index within the current row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            widx  <= '0;
        end else if (ld_i) begin
            cnt_q <= word_cnt_i;
            widx  <= '0;
        end else if (row_adv_i) begin
            widx  <= '0;
        end else if (word_adv_i) begin
            widx  <= widx + CW'(1);
        end
    end

    // Bus output registers: filled from memory data before the strobes start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr_o <= '0;
            bus_data_o <= '0;
        end else if (cap_i) begin
            bus_addr_o <= dst_ptr;
            bus_data_o <= mem_rd_data_i;
        end
    end

    assign mem_addr_o  = src_ptr;
    assign cnt_zero_o  = (cnt_q == '0);
    assign last_word_o = ((widx + CW'(1)) == cnt_q);
endmodule

// File: rtl/rsq_row.sv
// Row bookkeeping: the row group being loaded and the row group being shown.
// Assumes: latch_i and row_adv_i come from the controller in separate cycles.
module rsq_row #(
    parameter int ROWS = 16,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic          latch_i,
    input  logic          row_adv_i,
    output logic          last_row_o,
    output logic [RW-1:0] row_sel_o
);
    logic [RW-1:0] load_row;

    // Row being filled: cleared at start, stepped after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         load_row <= '0;
        else if (ld_i)      load_row <= '0;
        else if (row_adv_i) load_row <= load_row + RW'(1);
    end

    // Displayed row: switches only on the edge that ends the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_sel_o <= '0;
        else if (latch_i) row_sel_o <= load_row;
    end

    assign last_row_o = (load_row == RW'(ROWS - 1));

    // R7: the row select holds while the strobe is high, then shows the latched row.
    a_r7_hold_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |-> $stable(row_sel_o));
    a_r7_takes_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> (row_sel_o == $past(load_row)));
endmodule

// File: rtl/rsq_ctrl.sv
// Sequencing state machine: per word read, wait, setup, select, write;
// per row strobe and advance; frame end after the last row.
// Assumes: req_zero_i reflects word_cnt_i in the start cycle and
// cnt_zero_i reflects the captured count afterwards.
module rsq_ctrl
    import rsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic req_zero_i,
    input  logic cnt_zero_i,
    input  logic last_word_i,
    input  logic last_row_i,
    output logic ld_o,
    output logic rd_o,
    output logic cap_o,
    output logic word_adv_o,
    output logic latch_o,
    output logic row_adv_o,
    output logic done_o,
    output logic busy_o,
    output logic cs_o,
    output logic we_o
);
    rsq_state_e st, st_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state choice.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start_i) st_nx = req_zero_i ? ST_LATCH : ST_READ;
            ST_READ:  st_nx = ST_WAIT;
            ST_WAIT:  st_nx = ST_SETUP;
            ST_SETUP: st_nx = ST_SEL;
            ST_SEL:   st_nx = ST_WRITE;
            ST_WRITE: st_nx = last_word_i ? ST_LATCH : ST_READ;
            ST_LATCH: st_nx = ST_NEXT;
            ST_NEXT:  st_nx = last_row_i ? ST_IDLE
                                         : (cnt_zero_i ? ST_LATCH : ST_READ);
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Decoded controls.
    assign ld_o       = (st == ST_IDLE) && start_i;
    assign rd_o       = (st == ST_READ);
    assign cap_o      = (st == ST_WAIT);
    assign word_adv_o = (st == ST_WRITE);
    assign latch_o    = (st == ST_LATCH);
    assign row_adv_o  = (st == ST_NEXT) && !last_row_i;
    assign done_o     = (st == ST_NEXT) && last_row_i;
    assign busy_o     = (st != ST_IDLE);
    assign cs_o       = (st == ST_SEL) || (st == ST_WRITE);
    assign we_o       = (st == ST_WRITE);

    // R5: the write strobe rises only after a cycle of chip select alone.
    a_r5_we_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_o) |-> ($past(cs_o) && cs_o));
    // R8: frame-done is one cycle wide and leaves the sequencer idle.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

// File: rtl/rsq_top.sv
// Row scan transfer sequencer top: streams one row group of words per scan
// row from memory to the panel bus, strobes the second-level latch, moves
// the row select, and repeats for ROWS groups per frame.
// Assumes: a synchronous memory with one cycle of read latency.
module rsq_top #(
    parameter int AW        = 24,
    parameter int DW        = 16,
    parameter int MAX_WORDS = 4096,
    parameter int ROWS      = 16,
    localparam int CW       = $clog2(MAX_WORDS + 1),
    localparam int RW       = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] src_base_i,
    input  logic [AW-1:0] dst_base_i,
    input  logic [CW-1:0] word_cnt_i,
    output logic          busy_o,
    output logic          frame_done_o,
    output logic          mem_rd_en_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [DW-1:0] mem_rd_data_i,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_data_o,
    output logic          bus_cs_o,
    output logic          bus_we_o,
    output logic          row_latch_o,
    output logic [RW-1:0] row_sel_o
);
    logic ld, cap, word_adv, row_adv;
    logic cnt_zero, last_word, last_row, req_zero;

    assign req_zero = (word_cnt_i == '0);

    rsq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_zero_i(req_zero),
        .cnt_zero_i(cnt_zero), .last_word_i(last_word), .last_row_i(last_row),
        .ld_o(ld), .rd_o(mem_rd_en_o), .cap_o(cap), .word_adv_o(word_adv),
        .latch_o(row_latch_o), .row_adv_o(row_adv), .done_o(frame_done_o),
        .busy_o(busy_o), .cs_o(bus_cs_o), .we_o(bus_we_o)
    );

    rsq_ptrs #(.AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .src_base_i(src_base_i),
        .dst_base_i(dst_base_i), .word_cnt_i(word_cnt_i), .cap_i(cap),
        .word_adv_i(word_adv), .row_adv_i(row_adv), .mem_rd_data_i(mem_rd_data_i),
        .mem_addr_o(mem_addr_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
        .cnt_zero_o(cnt_zero), .last_word_o(last_word)
    );

    rsq_row #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .latch_i(row_latch_o),
        .row_adv_i(row_adv), .last_row_o(last_row), .row_sel_o(row_sel_o)
    );

    // R5: address and data stay put while the chip select is asserted.
    a_r5_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_o && $past(bus_cs_o)) |-> ($stable(bus_addr_o) && $stable(bus_data_o)));
    // R6: the row strobe never overlaps a bus access.
    a_r6_strobe_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        row_latch_o |-> !bus_cs_o);
    // R10: no memory read is issued outside a frame.
    a_r10_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> busy_o);
endmodule

// File: tb/tb_rsq_top.sv
// Directed bench for rsq_top: one task per scenario, each checking its results.
module tb_rsq_top;
    localparam int AW = 24, DW = 16, CW = 13, RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] src_base_i = '0, dst_base_i = '0;
    logic [CW-1:0] word_cnt_i = '0;
    logic          busy_o, frame_done_o, mem_rd_en_o, bus_cs_o, bus_we_o, row_latch_o;
    logic [AW-1:0] mem_addr_o, bus_addr_o;
    logic [DW-1:0] mem_rd_data_i = '0, bus_data_o;
    logic [RW-1:0] row_sel_o;

    always #2 clk = ~clk;   // 250 MHz

    rsq_top dut (.*);

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return DW'(a * 24'h9E37) ^ 16'h5A3C;
    endfunction

    // Source memory model: one cycle read latency.
    always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= pat(mem_addr_o);

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor state (expected values come from the requirements).
    bit            mon_on = 0;
    logic [AW-1:0] m_src, m_dst;
    int            m_n, m_row, m_widx;
    int            e_data, e_order, e_cnt, e_row, n_wr, n_lat, n_rd;
    bit            pend_row;
    logic          p_cs, p_we, pp_cs;
    logic [AW-1:0] pp_addr;
    logic [DW-1:0] pp_data;
    logic [RW-1:0] p_sel;

    always @(negedge clk) begin
        if (mon_on) begin
            if (pend_row) begin
                if (row_sel_o != RW'(m_row)) e_row++;        // R7
                m_row++; m_widx = 0; pend_row = 0;
            end
            if (mem_rd_en_o) n_rd++;
            if (bus_we_o && !p_we) begin
                if (bus_addr_o != m_dst + AW'(2 * m_widx)) e_data++;                 // R4
                if (bus_data_o != pat(m_src + AW'(m_row * m_n + m_widx))) e_data++;  // R3
                if (!(p_cs && !pp_cs && bus_cs_o)) e_order++;                        // R5
                if (bus_addr_o != pp_addr || bus_data_o != pp_data) e_order++;       // R5
                m_widx++; n_wr++;
            end
            if (row_latch_o) begin
                if (m_widx != m_n) e_cnt++;                  // R6
                if (bus_cs_o) e_order++;                     // R6
                if (row_sel_o != p_sel) e_row++;             // R7
                n_lat++; pend_row = 1;
            end
        end
        pp_cs = p_cs; p_cs = bus_cs_o; p_we = bus_we_o;
        pp_addr = bus_addr_o; pp_data = bus_data_o; p_sel = row_sel_o;
    end

    // Runs one frame; returns the number of cycles to frame-done (-1 on timeout).
    task automatic run_frame(input logic [AW-1:0] s, input logic [AW-1:0] d,
                             input int n, input bit poke, output int cyc);
        int k;
        m_src = s; m_dst = d; m_n = n; m_row = 0; m_widx = 0; pend_row = 0;
        e_data = 0; e_order = 0; e_cnt = 0; e_row = 0; n_wr = 0; n_lat = 0; n_rd = 0;
        mon_on = 1;
        @(negedge clk);
        src_base_i = s; dst_base_i = d; word_cnt_i = CW'(n); start_i = 1;
        k = 0; cyc = -1;
        while (k < 5000) begin
            @(negedge clk);
            k++;
            start_i = 0;
            if (k == 1) chk(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
            if (poke && k == 7) begin   // R9: start while busy with other settings
                src_base_i = 24'h00F000; dst_base_i = 24'h000100; word_cnt_i = 13'd5; start_i = 1;
            end
            if (frame_done_o) begin cyc = k; break; end
        end
        start_i = 0;
        @(negedge clk);
        chk(busy_o === 1'b0, "R2 idle after frame", busy_o, 0);
        mon_on = 0;
    endtask

    task automatic check_frame(input string tag, input int n, input int cyc);
        chk(cyc == 16 * (5 * n + 2), {tag, " R8 frame length"}, cyc, 16 * (5 * n + 2));
        chk(n_wr == 16 * n, {tag, " R3 write count"}, n_wr, 16 * n);
        chk(n_rd == 16 * n, {tag, " R3 read count"}, n_rd, 16 * n);
        chk(e_data == 0, {tag, " R3/R4 address and data"}, e_data, 0);
        chk(e_order == 0, {tag, " R5/R6 strobe order"}, e_order, 0);
        chk(e_cnt == 0, {tag, " R6 strobe after last word"}, e_cnt, 0);
        chk(n_lat == 16, {tag, " R8 strobes per frame"}, n_lat, 16);
        chk(e_row == 0 && row_sel_o == 4'd15, {tag, " R7 row select"}, row_sel_o, 15);
    endtask

    task automatic t_reset();
        chk(busy_o === 0 && frame_done_o === 0, "R1 busy/done", {busy_o, frame_done_o}, 0);
        chk(bus_cs_o === 0 && bus_we_o === 0, "R1 bus strobes", {bus_cs_o, bus_we_o}, 0);
        chk(row_latch_o === 0 && mem_rd_en_o === 0, "R1 strobe/read", {row_latch_o, mem_rd_en_o}, 0);
        chk(row_sel_o === 4'd0, "R1 row select", row_sel_o, 0);
    endtask

    task automatic t_basic();
        int c;
        run_frame(24'h000200, 24'h400000, 3, 0, c);
        check_frame("basic", 3, c);
    endtask

    task automatic t_zero();     // R10
        int c;
        run_frame(24'h000010, 24'h400000, 0, 0, c);
        check_frame("R10 zero", 0, c);
    endtask

    task automatic t_busy_start();   // R9
        int c;
        run_frame(24'h001000, 24'h400040, 2, 1, c);
        check_frame("R9 start ignored", 2, c);
    endtask

    task automatic t_second_frame();  // R8 wrap to row 0, R11 count field width
        int c;
        run_frame(24'hFFFFF0, 24'h4000FE, 1, 0, c);
        check_frame("R8 rewrap", 1, c);
        run_frame(24'h000000, 24'h400000, 20, 0, c);
        check_frame("R11 long row", 20, c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_basic();
        t_zero();
        t_busy_start();
        t_second_frame();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule